// File: doc/BRIEF.md
# CAN CRC-15 Generator and Checker

This block divides a serial CAN bit stream by the 15-bit CAN generator polynomial, x^15 + x^14 + x^10 + x^8 + x^7 + x^4 + x^3 + 1. The division uses modulo-2 arithmetic, so every step is a shift and an XOR. Upstream logic strobes one bit per enabled cycle, starting at start-of-frame and ending with the last data bit. The remainder register then holds the 15-bit code that a transmitter appends in place of fifteen zero bits.

A receiver keeps shifting after the data and passes the 15 received CRC bits through the same register. When the frame is intact, the register returns to zero. In check mode the block raises a pass flag when the register is zero and more than 15 bits have been consumed since the last clear. The block does not do framing or destuffing, and it does not decide which bits to feed.

Top module: `can_crc15_unit`

## Requirements
- R1: After reset, and on the cycle after `clear_i` is sampled high, `crc_o` is 0 and `crc_ok_o` is 0. `clear_i` takes priority over `bit_valid_i` in the same cycle.
- R2: On each clock edge where `bit_valid_i` is 1 and `clear_i` is 0, the block computes feedback f = `bit_i` XOR `crc_o[14]`. The register then becomes `{crc_o[13:0],1'b0}` XOR (f ? 15'h4599 : 0), and the new value is visible after that edge.
- R3: When `bit_valid_i` is 0 (and `clear_i` is 0), `bit_i` is ignored and `crc_o` and the consumed-bit count hold.
- R4: In generate mode (`check_mode_i` = 0), after a message of N bits has been fed MSB first from a clear, `crc_o` equals the remainder of (message · x^15) divided by the generator.
- R5: In check mode (`check_mode_i` = 1), after a message is fed and then followed by its 15-bit remainder (bit 14 first), `crc_o` is 0 and `crc_ok_o` is 1.
- R6: If any single message bit is inverted before the correct remainder is fed, `crc_o` is nonzero and `crc_ok_o` is 0.
- R7: `crc_ok_o` is 0 whenever `check_mode_i` is 0, whatever the register holds. The mode input acts on the flag in the same cycle.
- R8: `crc_ok_o` needs more than 15 bits consumed since the last clear. The consumed-bit count saturates at its maximum (127 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of remainder and bit count |
| bit_valid_i | input | 1 | Consume `bit_i` on this edge |
| bit_i | input | 1 | Serial frame bit |
| check_mode_i | input | 1 | 0 = generate, 1 = check |
| crc_o | output | 15 | Current remainder register |
| crc_ok_o | output | 1 | Zero remainder in check mode after more than 15 bits |

## Verification
The assertions assume that `bit_i`, `bit_valid_i`, `clear_i` and `check_mode_i` hold known values at every rising edge once reset is released. The step properties compare each new remainder against the previous one, so they rely on no bit being consumed in a cycle where `clear_i` is also high. The stimulus changes every input only on the falling edge and releases reset before the first bit. It changes `check_mode_i` only while `bit_valid_i` is low, which keeps both assumptions intact.

// File: rtl/can_crc_pkg.sv
package can_crc_pkg;
    localparam int                 CRC_W     = 15;
    localparam logic [CRC_W-1:0]   CRC_POLY  = 15'h4599;
    localparam int                 CNT_W_DEF = 7;

    typedef enum logic {
        MODE_GEN   = 1'b0,
        MODE_CHECK = 1'b1
    } crc_mode_e;
endpackage

// File: rtl/crc15_step.sv
module crc15_step #(
    parameter int               W    = can_crc_pkg::CRC_W,
    parameter logic [W-1:0]     POLY = can_crc_pkg::CRC_POLY
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    output logic [W-1:0] rem_o
);
    logic feedback;
    assign feedback = bit_i ^ rem_i[W-1];

    // One shift-and-subtract step of the polynomial division, unrolled per bit.
    for (genvar g = 0; g < W; g++) begin : g_tap
        if (g == 0) begin : g_lsb
            assign rem_o[g] = feedback & POLY[g];
        end else begin : g_mid
            assign rem_o[g] = rem_i[g-1] ^ (feedback & POLY[g]);
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = can_crc_pkg::CNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_cnt_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_cnt_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/can_crc15_unit.sv
module can_crc15_unit #(
    parameter int                          CRC_W = can_crc_pkg::CRC_W,
    parameter logic [CRC_W-1:0]            POLY  = can_crc_pkg::CRC_POLY,
    parameter int                          CNT_W = can_crc_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             check_mode_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             crc_ok_o
);
    import can_crc_pkg::*;

    localparam logic [CNT_W-1:0] MIN_BITS = CNT_W'(CRC_W);

    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } state_t;

    state_t           st_d, st_q;
    logic [CRC_W-1:0] rem_step;
    logic [CNT_W-1:0] bit_cnt;
    crc_mode_e        mode;

    assign mode = crc_mode_e'(check_mode_i);

    crc15_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .rem_i (st_q.rem),
        .bit_i (bit_i),
        .rem_o (rem_step)
    );

    sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clear_i),
        .inc_i (bit_valid_i),
        .cnt_o (bit_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.rem = '0;
        end else if (bit_valid_i) begin
            st_d.rem = rem_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o    = st_q.rem;
    assign crc_ok_o = (mode == MODE_CHECK) && (st_q.rem == '0) && (bit_cnt > MIN_BITS);

    assert_clear_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == '0 && !crc_ok_o));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !bit_valid_i) |=> $stable(crc_o));
    assert_shift_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !clear_i && (bit_i == crc_o[CRC_W-1]))
        |=> crc_o == {$past(crc_o[CRC_W-2:0]), 1'b0});
    assert_shift_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !clear_i && (bit_i != crc_o[CRC_W-1]))
        |=> crc_o == ({$past(crc_o[CRC_W-2:0]), 1'b0} ^ POLY));
    assert_gen_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !check_mode_i |-> !crc_ok_o);
    assert_ok_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok_o |-> crc_o == '0);
endmodule

// File: tb/test_can_crc15_unit.sv
`timescale 1ns/1ps
module test_can_crc15_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        bit_valid_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        check_mode_i = 1'b0;
    logic [14:0] crc_o;
    logic        crc_ok_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    can_crc15_unit i_can_crc15_unit (
        .clk (clk), .rst_n (rst_n), .clear_i (clear_i),
        .bit_valid_i (bit_valid_i), .bit_i (bit_i), .check_mode_i (check_mode_i),
        .crc_o (crc_o), .crc_ok_o (crc_ok_o)
    );

    typedef struct packed {
        logic [7:0]  len;
        logic [63:0] data;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1,  64'h1},
        '{8'd2,  64'h2},
        '{8'd5,  64'h0},
        '{8'd8,  64'hA5},
        '{8'd11, 64'h7FF},
        '{8'd19, 64'h2AB55},
        '{8'd32, 64'hDEADBEEF},
        '{8'd64, 64'h0123456789ABCDEF}
    };

    // Long division of message*x^15 by the full 16-bit generator 0xC599.
    function automatic logic [14:0] ref_rem(input logic [63:0] d, input int len);
        logic [79:0] w;
        w = {16'b0, d} << 15;
        for (int i = len + 14; i >= 15; i--) begin
            if (w[i]) w[i -: 16] = w[i -: 16] ^ 16'hC599;
        end
        return w[14:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] d, input int len);
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk);
            bit_valid_i = 1'b1;
            bit_i       = d[i];
        end
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [14:0] r;
        logic [14:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset crc", 32'(crc_o), 32'h0);
        check("R1 reset ok", 32'(crc_ok_o), 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            r = ref_rem(VECS[v].data, int'(VECS[v].len));
            check_mode_i = 1'b0;
            do_clear();
            send(VECS[v].data, int'(VECS[v].len));
            check("R4 generate remainder", 32'(crc_o), 32'(r));
            check_mode_i = 1'b1;
            do_clear();
            send(VECS[v].data, int'(VECS[v].len));
            send({49'b0, r}, 15);
            check("R5 check ok", 32'(crc_ok_o), 32'h1);
            do_clear();
            send(VECS[v].data ^ (64'h1 << (VECS[v].len / 2)), int'(VECS[v].len));
            send({49'b0, r}, 15);
            check("R6 error nonzero", 32'(crc_o != 15'h0), 32'h1);
            check("R6 error flag", 32'(crc_ok_o), 32'h0);
        end

        // R2: single steps from zero
        check_mode_i = 1'b0;
        do_clear();
        send(64'h1, 1);
        check("R2 step fold", 32'(crc_o), 32'h4599);
        send(64'h1, 1);
        check("R2 step bit14 cancels", 32'(crc_o), 32'h0B32);

        // R3: invalid bits ignored
        held = crc_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bit_i = k[0];
        end
        check("R3 hold", 32'(crc_o), 32'(held));

        // R1: clear beats valid in the same cycle
        @(negedge clk);
        clear_i = 1'b1; bit_valid_i = 1'b1; bit_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0; bit_valid_i = 1'b0;
        check("R1 clear priority", 32'(crc_o), 32'h0);

        // R7: valid codeword in generate mode, flag follows mode
        r = ref_rem(64'hA5, 8);
        check_mode_i = 1'b0;
        do_clear();
        send(64'hA5, 8);
        send({49'b0, r}, 15);
        check("R7 gen mode low", 32'(crc_ok_o), 32'h0);
        check_mode_i = 1'b1;
        @(negedge clk);
        check("R7 mode switch high", 32'(crc_ok_o), 32'h1);

        // R8: bit count threshold
        do_clear();
        check("R8 cleared not ok", 32'(crc_ok_o), 32'h0);
        send(64'h0, 15);
        check("R8 fifteen bits not ok", 32'(crc_ok_o), 32'h0);
        send(64'h0, 1);
        check("R8 sixteen bits ok", 32'(crc_ok_o), 32'h1);
        send(64'h0, 64);
        send(64'h0, 64);
        check("R8 saturated still ok", 32'(crc_ok_o), 32'h1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule